// File: doc/BRIEF.md
# Configuration Bus Width Detector

At the start of an image load, a parallel configuration port may be driven at one of three widths: 8, 16 or 32 data bits per bus clock. This block watches a 32-bit data input during that phase and finds a fixed 16-byte synchronisation pattern. The pattern can arrive one byte, two bytes or four bytes per valid cycle. The block reports the width it found as a 2-bit code and raises a done flag.

After detection it drives one enable per byte lane. Lanes that the detected width does not use are released, and the enables for used lanes stay asserted. Three matchers run side by side, one per width. Each matcher compares its own slice of the bus against the part of the pattern due on that beat. The first matcher to complete decides the width, and the result is then frozen until reset. If 16 valid cycles pass with no match, the block raises an error flag instead.

Top module: `cfg_width_detect`

## Requirements
- R1: After reset, done_o and error_o are 0, width_o is 2'b00 and lane_en_o is 4'b1111.
- R2: Four valid words 0x000000DD, 0x11223344, 0x55667788, 0x99AABBCC on data_i set width_o to 2'b11, done_o to 1 and lane_en_o to 4'b1111 one clock after the fourth word. Before that, done_o stays 0.
- R3: Eight valid words whose D[15:0] carry 0x0000, 0x00DD, 0x1122, 0x3344, 0x5566, 0x7788, 0x99AA, 0xBBCC set width_o to 2'b10 and done_o one clock after the eighth word. D[31:16] has no effect on this result.
- R4: Sixteen valid words whose D[7:0] carry 00, 00, 00, DD, 11, 22, 33, 44, 55, 66, 77, 88, 99, AA, BB, CC set width_o to 2'b01 and done_o one clock after the sixteenth word. D[31:8] has no effect on this result.
- R5: width_o is 2'b00 when no width is found, 2'b01 for x8, 2'b10 for x16 and 2'b11 for x32.
- R6: Bit i of lane_en_o enables byte lane D[8i+7:8i]. It is 4'b1111 before detection and after an error, 4'b0001 after x8, 4'b0011 after x16 and 4'b1111 after x32.
- R7: A cycle with valid_i low advances no matcher and no timeout count, whatever data_i holds.
- R8: When a word does not match, the matcher returns to its first beat. Matching the full pattern afterwards still completes detection.
- R9: If 16 valid cycles pass with no completed match, error_o is set one clock after the sixteenth. width_o then stays 2'b00, done_o stays 0, and error_o holds until reset, even if a valid pattern follows.
- R10: Once done_o is set, width_o and lane_en_o do not change until reset, whatever valid data follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Data word present this cycle |
| data_i | input | 32 | Configuration data bus |
| done_o | output | 1 | A width has been detected |
| error_o | output | 1 | No pattern found within the window |
| width_o | output | 2 | Detected width code |
| lane_en_o | output | 4 | Per-byte-lane enables |

## Verification
Suppose a matcher's beat index is off by one, or advances on an invalid cycle. At the ports, done_o would then appear one clock early, or one clock late, or not at all. In the last case error_o would rise after the sixteenth valid word. Any error in slicing or lane masking shows up as a wrong width_o or lane_en_o on the first clock after the final pattern word. The bench checks done_o and error_o on the clock before the final word and on the clock after it. It also checks that the outputs stay frozen while noise follows.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

   typedef enum logic [1:0] {
      WID_NONE = 2'b00,
      WID_X8   = 2'b01,
      WID_X16  = 2'b10,
      WID_X32  = 2'b11
   } width_e;

   localparam int SYNC_BYTES = 16;

   // byte k of the synchronisation pattern, first byte on the wire is k=0
   function automatic logic [7:0] sync_byte(input int unsigned k);
      logic [7:0] v;
      if (k < 3)       v = 8'h00;
      else if (k == 3) v = 8'hDD;
      else             v = 8'(k - 3) * 8'h11;
      return v;
   endfunction

   function automatic logic [3:0] lane_mask(input width_e w);
      logic [3:0] m;
      case (w)
         WID_X8:  m = 4'b0001;
         WID_X16: m = 4'b0011;
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cwd_matcher.sv
module cwd_matcher
   import cwd_pkg::*;
#(
   parameter int BYTES_PER_BEAT = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        valid_i,
   input  logic [BYTES_PER_BEAT*8-1:0] slice_i,
   output logic                        hit_o
);

   localparam int BEATS  = SYNC_BYTES / BYTES_PER_BEAT;
   localparam int IDX_W  = $clog2(BEATS);
   localparam int SLICE_W = BYTES_PER_BEAT * 8;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

   logic [IDX_W-1:0]   beat_q;
   logic [SLICE_W-1:0] expect_w;
   logic               match_w;

   // first pattern byte of a beat lands in the most significant byte of the slice
   always_comb begin
      expect_w = '0;
      for (int j = 0; j < BYTES_PER_BEAT; j++) begin
         expect_w[SLICE_W-1-8*j -: 8] = sync_byte(int'(beat_q) * BYTES_PER_BEAT + j);
      end
   end

   assign match_w = (slice_i == expect_w);
   assign hit_o   = valid_i && match_w && (beat_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (valid_i) begin
         if (match_w && beat_q != LAST) beat_q <= beat_q + 1'b1;
         else                           beat_q <= '0;
      end
   end

endmodule

// File: rtl/cfg_width_detect.sv
module cfg_width_detect
   import cwd_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int TIMEOUT_BEATS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   input  logic [DATA_W-1:0]   data_i,
   output logic                done_o,
   output logic                error_o,
   output logic [1:0]          width_o,
   output logic [DATA_W/8-1:0] lane_en_o
);

   localparam int LANES  = DATA_W / 8;
   localparam int NWID   = 3;
   localparam int CNT_W  = $clog2(TIMEOUT_BEATS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_BEATS - 1);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cfg_width_detect: DATA_W must be 32");
      end
      if (TIMEOUT_BEATS < SYNC_BYTES) begin : g_bad_timeout
         $error("cfg_width_detect: TIMEOUT_BEATS must cover the x8 pattern");
      end
   endgenerate

   logic [NWID-1:0] hit_w;   // bit g: matcher with 2**g bytes per beat

   generate
      for (genvar g = 0; g < NWID; g++) begin : g_match
         cwd_matcher #(.BYTES_PER_BEAT(1 << g)) u_m (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (valid_i),
            .slice_i (data_i[(8 << g)-1:0]),
            .hit_o   (hit_w[g])
         );
      end
   endgenerate

   width_e          found_w;
   width_e          width_q;
   logic            done_q, err_q;
   logic [CNT_W-1:0] cnt_q;

   // widest completing matcher wins
   always_comb begin
      if (hit_w[2])      found_w = WID_X32;
      else if (hit_w[1]) found_w = WID_X16;
      else if (hit_w[0]) found_w = WID_X8;
      else               found_w = WID_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_q <= WID_NONE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (valid_i && !done_q && !err_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (found_w != WID_NONE) begin
            width_q <= found_w;
            done_q  <= 1'b1;
         end else if (cnt_q == CNT_LAST) begin
            err_q <= 1'b1;
         end
      end
   end

   assign done_o    = done_q;
   assign error_o   = err_q;
   assign width_o   = width_q;
   assign lane_en_o = LANES'(lane_mask(width_q));

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
   parameter int DATA_W        = 32,
   parameter int TIMEOUT_BEATS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                valid_i,
   input logic                done_o,
   input logic                error_o,
   input logic [1:0]          width_o,
   input logic [DATA_W/8-1:0] lane_en_o
);

   localparam int CW = $clog2(TIMEOUT_BEATS + 2);
   logic [CW-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                            seen_q <= '0;
      else if (valid_i && !done_o && !error_o) seen_q <= seen_q + 1'b1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!done_o && !error_o && width_o == 2'b00)); // R1
   AST_DONE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> width_o != 2'b00); // R5
   AST_ERR_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n) error_o |-> (width_o == 2'b00 && !done_o)); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) error_o |=> error_o); // R9
   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (!done_o && !error_o) |-> seen_q < CW'(TIMEOUT_BEATS)); // R9
   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> (done_o && $stable(width_o) && $stable(lane_en_o))); // R10
   AST_LANES_X8: assert property (@(posedge clk) disable iff (!rst_n) (done_o && width_o == 2'b01) |-> lane_en_o == 4'b0001); // R6
   AST_LANES_X16: assert property (@(posedge clk) disable iff (!rst_n) (done_o && width_o == 2'b10) |-> lane_en_o == 4'b0011); // R6
   AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> lane_en_o == 4'b1111); // R6
   AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) (!valid_i && !done_o && !error_o) |=> (!done_o && !error_o)); // R7

endmodule

bind cfg_width_detect cwd_checker #(
   .DATA_W(DATA_W), .TIMEOUT_BEATS(TIMEOUT_BEATS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .done_o(done_o),
   .error_o(error_o), .width_o(width_o), .lane_en_o(lane_en_o)
);

// File: tb/sim_cfg_width_detect.sv
module sim_cfg_width_detect;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] data_i = '0;
   logic        done_o, error_o;
   logic [1:0]  width_o;
   logic [3:0]  lane_en_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_width_detect u0 (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .data_i(data_i),
      .done_o(done_o), .error_o(error_o), .width_o(width_o), .lane_en_o(lane_en_o)
   );

   logic [7:0] pat [16] = '{8'h00, 8'h00, 8'h00, 8'hDD, 8'h11, 8'h22, 8'h33, 8'h44,
                            8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC};

   function automatic logic [31:0] beat_word(int bpb, int b, logic [31:0] noise);
      logic [31:0] w = '0;
      logic [31:0] m;
      for (int j = 0; j < bpb; j++) w = (w << 8) | 32'(pat[b*bpb + j]);
      m = (bpb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (bpb*8)) - 1);
      return w | (noise & ~m);
   endfunction

   function automatic logic [1:0] exp_code(int bpb);
      return (bpb == 1) ? 2'b01 : (bpb == 2) ? 2'b10 : 2'b11;
   endfunction

   function automatic logic [3:0] exp_lanes(int bpb);
      return (bpb == 1) ? 4'b0001 : (bpb == 2) ? 4'b0011 : 4'b1111;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(logic v, logic [31:0] d);
      @(negedge clk);
      valid_i = v;
      data_i  = d;
   endtask

   task automatic settle();
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = $urandom;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; valid_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", done_o, 0, "done after reset");
      check("R1", error_o, 0, "error after reset");
      check("R1", width_o, 0, "width after reset");
      check("R6", lane_en_o, 4'hF, "lanes before detection");
   endtask

   // sends one pattern at width bpb with optional idle gaps, then checks
   task automatic run_pattern(int bpb, bit gaps, string req);
      int beats = 16 / bpb;
      do_reset();
      for (int b = 0; b < beats; b++) begin
         if (gaps && ($urandom % 3 == 0)) push(1'b0, $urandom); // R7 idle cycle
         if (b == beats - 1) begin
            @(negedge clk);
            valid_i = 1'b0;
            check(req, done_o, 0, "done before final word");
            check("R7", error_o, 0, "error before final word");
         end
         push(1'b1, beat_word(bpb, b, $urandom));
      end
      settle();
      check(req, done_o, 1, "done after final word");
      check("R5", width_o, 32'(exp_code(bpb)), "width code");
      check("R6", lane_en_o, 32'(exp_lanes(bpb)), "lane enables");
      for (int k = 0; k < 6; k++) push(1'b1, $urandom);
      push(1'b1, 32'h000000DD);
      settle();
      check("R10", width_o, 32'(exp_code(bpb)), "width after extra data");
      check("R10", lane_en_o, 32'(exp_lanes(bpb)), "lanes after extra data");
   endtask

   initial begin
      void'($urandom(32'd1234));
      // directed widths
      run_pattern(4, 1'b0, "R2");
      run_pattern(2, 1'b0, "R3");
      run_pattern(1, 1'b0, "R4");
      // random widths with idle gaps and noisy upper lanes
      for (int t = 0; t < 12; t++) begin
         int sel = $urandom % 3;
         run_pattern(1 << sel, 1'b1, (sel == 0) ? "R4" : (sel == 1) ? "R3" : "R2");
      end

      // R8: broken x32 pattern, then a clean one
      do_reset();
      push(1'b1, 32'h000000DD);
      push(1'b1, 32'h12345678);
      for (int b = 0; b < 4; b++) push(1'b1, beat_word(4, b, 0));
      settle();
      check("R8", done_o, 1, "done after restart");
      check("R8", width_o, 2'b11, "width after restart");

      // R9: sixteen noise words never matching (low byte 0x5A)
      do_reset();
      for (int k = 0; k < 15; k++) push(1'b1, {$urandom} & 32'hFFFF_FF00 | 32'h5A);
      @(negedge clk);
      valid_i = 1'b0;
      check("R9", error_o, 0, "error before 16th word");
      push(1'b1, 32'hABCD_005A);
      settle();
      check("R9", error_o, 1, "error after 16th word");
      check("R9", width_o, 0, "width on error");
      check("R9", done_o, 0, "done on error");
      check("R6", lane_en_o, 4'hF, "lanes on error");
      for (int b = 0; b < 4; b++) push(1'b1, beat_word(4, b, 0));
      settle();
      check("R9", error_o, 1, "error sticky");
      check("R9", done_o, 0, "no detection after error");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule